// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block produces the source and destination address stream of one DMA channel that copies a rectangular region of memory, one line at a time. A descriptor is loaded while the channel is idle. It gives the two start addresses, a signed step applied after every access on each side, a byte-count word, an iteration count for the outer loop, and signed adjustments applied on each side once the whole transfer ends. The byte-count word can also carry one signed line offset. That offset is added at the end of every line except the last, to the source, the destination or both. It lets the channel skip the unused part of each line of a larger picture.

While running, the block issues one access per cycle with no gaps between lines. It then returns to idle and raises a done flag, an optional interrupt, and a one-cycle start pulse for a linked channel. The pulse comes a fixed delay after done rises. The iteration count reloads from its stored value, so a new start with no new load repeats the same shape from the adjusted addresses. The data movement and channel arbitration sit outside this block. Accesses are `ACC_BYTES` (default 4) bytes wide.

Top module: `dma2d_addr_seq`

## Requirements
- R1: While `busy` is high, `acc_valid` is high every cycle, and `acc_src`/`acc_dst` show the current addresses. After each access, the 16-bit `desc_src_step` and `desc_dst_step`, sign-extended, are added to the source and destination addresses. When idle, the addresses hold unless a descriptor is loaded.
- R2: A line (inner loop) takes byte count / 4 accesses, and a transfer takes `desc_iters` lines. All of them are issued on consecutive cycles.
- R3: Count word decoding depends on `map_enable` and two enable bits. If `map_enable` is 1 and bit 31 (source enable) or bit 30 (destination enable) is set, bits 9:0 are the byte count and bits 29:10, sign-extended, are the line offset. If `map_enable` is 1 and neither enable bit is set, bits 29:0 are the byte count. If `map_enable` is 0, the whole word is the byte count and there is no line offset.
- R4: After the last access of every line except the final line, the line offset is added, together with the per-access step, to the source address if bit 31 is set and to the destination address if bit 30 is set.
- R5: After the final access, the source address gets its step plus `desc_src_last`, and the destination address gets its step plus `desc_dst_last`. The line offset is not applied at that point. All sums wrap modulo 2^32.
- R6: `done` rises, and `busy` falls, in the cycle after the final access. `done` stays high until a valid start or a `done_clr` pulse.
- R7: `irq` is high together with `done` when `desc_irq_en` was set, and low otherwise.
- R8: When `desc_link_en` is set, `link_trig` is a one-cycle pulse two cycles after `done` rises. Otherwise it stays low.
- R9: A start with a zero byte count, a byte count that is not a multiple of 4, or a zero iteration count sets `cfg_err` and issues no access. A valid start or a load clears `cfg_err`.
- R10: `start` and `desc_load` are ignored while `busy` is high.
- R11: At completion the iteration count reloads. A later start with no new load runs the same shape again from the adjusted addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_load | input | 1 | Load descriptor fields (idle only) |
| desc_src | input | 32 | Source start address |
| desc_dst | input | 32 | Destination start address |
| desc_src_step | input | OFF_W | Signed source step per access |
| desc_dst_step | input | OFF_W | Signed destination step per access |
| desc_count_word | input | 32 | Byte count word, optionally with line offset and enables |
| map_enable | input | 1 | Global enable for the line-offset layout of the count word |
| desc_iters | input | ITER_W | Number of lines |
| desc_src_last | input | 32 | Signed source adjustment at completion |
| desc_dst_last | input | 32 | Signed destination adjustment at completion |
| desc_irq_en | input | 1 | Raise irq at completion |
| desc_link_en | input | 1 | Pulse link_trig after completion |
| start | input | 1 | Start trigger |
| done_clr | input | 1 | Clear done and irq |
| acc_valid | output | 1 | An access is issued this cycle |
| acc_src | output | 32 | Current source address |
| acc_dst | output | 32 | Current destination address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete |
| irq | output | 1 | Completion interrupt |
| cfg_err | output | 1 | Last start was rejected |
| link_trig | output | 1 | Start pulse to the linked channel |

## Verification
On the final access of a transfer, the end of a line and the end of the whole transfer fall in the same cycle. Only the completion adjustment may be applied there; the line offset must not. The bench provokes this on every run, and on every access when the byte count is 4. It uses random offsets and adjustments whose sums differ, so a wrongly chosen or doubled term shows up in the address observed on the next cycle. A start and a load are also injected mid-run, and the address stream must continue unchanged.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
   localparam int WORD_W      = 32;
   localparam int CNT_SHORT_W = 10;
   localparam int LOFF_LSB    = 10;
   localparam int LOFF_MSB    = 29;
   localparam int SRC_EN_BIT  = 31;
   localparam int DST_EN_BIT  = 30;
   localparam int LOFF_W      = LOFF_MSB - LOFF_LSB + 1;

   typedef struct packed {
      logic [WORD_W-1:0] nbytes;
      logic [WORD_W-1:0] line_off;
      logic              src_line_en;
      logic              dst_line_en;
   } cnt_dec_t;
endpackage

// File: rtl/dma2d_cnt_decode.sv
module dma2d_cnt_decode
   import dma2d_pkg::*;
(
   input  logic [WORD_W-1:0] word_i,
   input  logic              map_en_i,
   output cnt_dec_t          dec_o
);
   always_comb begin
      dec_o = '0;
      if (map_en_i && (word_i[SRC_EN_BIT] || word_i[DST_EN_BIT])) begin
         dec_o.nbytes      = {{(WORD_W-CNT_SHORT_W){1'b0}}, word_i[CNT_SHORT_W-1:0]};
         dec_o.line_off    = {{(WORD_W-LOFF_W){word_i[LOFF_MSB]}}, word_i[LOFF_MSB:LOFF_LSB]};
         dec_o.src_line_en = word_i[SRC_EN_BIT];
         dec_o.dst_line_en = word_i[DST_EN_BIT];
      end else if (map_en_i) begin
         dec_o.nbytes = {2'b00, word_i[DST_EN_BIT-1:0]};
      end else begin
         dec_o.nbytes = word_i;
      end
   end
endmodule

// File: rtl/dma2d_addr_path.sv
module dma2d_addr_path
   import dma2d_pkg::*;
#(
   parameter int OFF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_addr_i,
   input  logic              step_i,
   input  logic              line_end_i,
   input  logic              xfer_end_i,
   input  logic              line_en_i,
   input  logic [OFF_W-1:0]  step_off_i,
   input  logic [WORD_W-1:0] line_off_i,
   input  logic [WORD_W-1:0] last_adj_i,
   output logic [WORD_W-1:0] addr_o
);
   logic [WORD_W-1:0] step_ext, extra, addr_q;

   assign step_ext = {{(WORD_W-OFF_W){step_off_i[OFF_W-1]}}, step_off_i};

   always_comb begin
      if (xfer_end_i)                   extra = last_adj_i;
      else if (line_end_i && line_en_i) extra = line_off_i;
      else                              extra = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (load_i)  addr_q <= load_addr_i;
      else if (step_i)  addr_q <= addr_q + step_ext + extra;
   end

   assign addr_o = addr_q;
endmodule

// File: rtl/dma2d_loop_ctrl.sv
module dma2d_loop_ctrl
   import dma2d_pkg::*;
#(
   parameter int ITER_W    = 15,
   parameter int ACC_BYTES = 4,
   parameter int LINK_DLY  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ITER_W-1:0] iters_i,
   input  logic [WORD_W-1:0] nbytes_i,
   input  logic              start_i,
   input  logic              done_clr_i,
   input  logic              irq_en_i,
   input  logic              link_en_i,
   output logic              busy_o,
   output logic              line_end_o,
   output logic              xfer_end_o,
   output logic              done_o,
   output logic              irq_o,
   output logic              err_o,
   output logic              link_o
);
   localparam int                ACC_LSB  = $clog2(ACC_BYTES);
   localparam logic [WORD_W-1:0] ACC_STEP = WORD_W'(ACC_BYTES);

   logic              busy_q, done_q, irq_q, err_q;
   logic [WORD_W-1:0] left_q;
   logic [ITER_W-1:0] iter_q, init_q;
   logic              aligned, shape_ok, go, bad;
   logic [LINK_DLY:0] lnk_q;

   generate
      if (ACC_LSB == 0) begin : g_byte_acc
         assign aligned = 1'b1;
      end else begin : g_wide_acc
         assign aligned = (nbytes_i[ACC_LSB-1:0] == '0);
      end
   endgenerate

   assign shape_ok   = (nbytes_i != '0) && aligned && (init_q != '0);
   assign go         = start_i && !busy_q && shape_ok;
   assign bad        = start_i && !busy_q && !shape_ok;
   assign line_end_o = busy_q && (left_q == ACC_STEP);
   assign xfer_end_o = line_end_o && (iter_q == ITER_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         irq_q  <= 1'b0;
         err_q  <= 1'b0;
         left_q <= '0;
         iter_q <= '0;
         init_q <= '0;
      end else begin
         if (load_i && !busy_q) begin
            init_q <= iters_i;
            iter_q <= iters_i;
            err_q  <= 1'b0;
         end
         if (go) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            err_q  <= 1'b0;
            left_q <= nbytes_i;
         end else if (bad) begin
            err_q <= 1'b1;
         end
         if (busy_q) begin
            if (line_end_o) begin
               left_q <= nbytes_i;
               iter_q <= xfer_end_o ? init_q : iter_q - 1'b1;
               if (xfer_end_o) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  irq_q  <= irq_en_i;
               end
            end else begin
               left_q <= left_q - ACC_STEP;
            end
         end else if (done_clr_i && !go) begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lnk_q[0] <= 1'b0;
      else        lnk_q[0] <= xfer_end_o && link_en_i;
   end

   generate
      for (genvar i = 1; i <= LINK_DLY; i++) begin : g_link_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lnk_q[i] <= 1'b0;
            else        lnk_q[i] <= lnk_q[i-1];
         end
      end
   endgenerate

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign irq_o  = irq_q;
   assign err_o  = err_q;
   assign link_o = lnk_q[LINK_DLY];
endmodule

// File: rtl/dma2d_addr_seq.sv
module dma2d_addr_seq
   import dma2d_pkg::*;
#(
   parameter int OFF_W     = 16,
   parameter int ITER_W    = 15,
   parameter int ACC_BYTES = 4,
   parameter int LINK_DLY  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desc_load,
   input  logic [WORD_W-1:0] desc_src,
   input  logic [WORD_W-1:0] desc_dst,
   input  logic [OFF_W-1:0]  desc_src_step,
   input  logic [OFF_W-1:0]  desc_dst_step,
   input  logic [WORD_W-1:0] desc_count_word,
   input  logic              map_enable,
   input  logic [ITER_W-1:0] desc_iters,
   input  logic [WORD_W-1:0] desc_src_last,
   input  logic [WORD_W-1:0] desc_dst_last,
   input  logic              desc_irq_en,
   input  logic              desc_link_en,
   input  logic              start,
   input  logic              done_clr,
   output logic              acc_valid,
   output logic [WORD_W-1:0] acc_src,
   output logic [WORD_W-1:0] acc_dst,
   output logic              busy,
   output logic              done,
   output logic              irq,
   output logic              cfg_err,
   output logic              link_trig
);
   localparam int SIDES = 2;

   generate
      if (OFF_W < 2 || OFF_W >= WORD_W) begin : g_bad_off
         $error("OFF_W must lie between 2 and WORD_W-1");
      end
      if (ITER_W < 1 || ITER_W > 16) begin : g_bad_iter
         $error("ITER_W must lie between 1 and 16");
      end
      if (ACC_BYTES < 1 || (ACC_BYTES & (ACC_BYTES - 1)) != 0) begin : g_bad_acc
         $error("ACC_BYTES must be a power of two");
      end
      if (LINK_DLY < 1) begin : g_bad_link
         $error("LINK_DLY must be at least 1");
      end
   endgenerate

   logic [OFF_W-1:0]  src_step_q, dst_step_q;
   logic [WORD_W-1:0] word_q, src_last_q, dst_last_q;
   logic              map_q, irq_en_q, link_en_q;
   logic              load_ok, line_end, xfer_end;
   cnt_dec_t          dec;

   logic [SIDES-1:0][WORD_W-1:0] ld_addr, last_adj, addr;
   logic [SIDES-1:0][OFF_W-1:0]  step_off;
   logic [SIDES-1:0]             line_en;

   assign load_ok = desc_load && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_step_q <= '0;
         dst_step_q <= '0;
         word_q     <= '0;
         src_last_q <= '0;
         dst_last_q <= '0;
         map_q      <= 1'b0;
         irq_en_q   <= 1'b0;
         link_en_q  <= 1'b0;
      end else if (load_ok) begin
         src_step_q <= desc_src_step;
         dst_step_q <= desc_dst_step;
         word_q     <= desc_count_word;
         src_last_q <= desc_src_last;
         dst_last_q <= desc_dst_last;
         map_q      <= map_enable;
         irq_en_q   <= desc_irq_en;
         link_en_q  <= desc_link_en;
      end
   end

   dma2d_cnt_decode u_dec (
      .word_i   (word_q),
      .map_en_i (map_q),
      .dec_o    (dec)
   );

   dma2d_loop_ctrl #(
      .ITER_W    (ITER_W),
      .ACC_BYTES (ACC_BYTES),
      .LINK_DLY  (LINK_DLY)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (desc_load),
      .iters_i    (desc_iters),
      .nbytes_i   (dec.nbytes),
      .start_i    (start),
      .done_clr_i (done_clr),
      .irq_en_i   (irq_en_q),
      .link_en_i  (link_en_q),
      .busy_o     (busy),
      .line_end_o (line_end),
      .xfer_end_o (xfer_end),
      .done_o     (done),
      .irq_o      (irq),
      .err_o      (cfg_err),
      .link_o     (link_trig)
   );

   assign ld_addr[0]  = desc_src;
   assign ld_addr[1]  = desc_dst;
   assign last_adj[0] = src_last_q;
   assign last_adj[1] = dst_last_q;
   assign step_off[0] = src_step_q;
   assign step_off[1] = dst_step_q;
   assign line_en[0]  = dec.src_line_en;
   assign line_en[1]  = dec.dst_line_en;

   generate
      for (genvar s = 0; s < SIDES; s++) begin : g_side
         dma2d_addr_path #(.OFF_W(OFF_W)) u_path (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (load_ok),
            .load_addr_i (ld_addr[s]),
            .step_i      (busy),
            .line_end_i  (line_end),
            .xfer_end_i  (xfer_end),
            .line_en_i   (line_en[s]),
            .step_off_i  (step_off[s]),
            .line_off_i  (dec.line_off),
            .last_adj_i  (last_adj[s]),
            .addr_o      (addr[s])
         );
      end
   endgenerate

   assign acc_valid = busy;
   assign acc_src   = addr[0];
   assign acc_dst   = addr[1];
endmodule

// File: rtl/dma2d_addr_seq_chk.sv
module dma2d_addr_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        desc_load,
   input logic        acc_valid,
   input logic [31:0] acc_src,
   input logic [31:0] acc_dst,
   input logic        busy,
   input logic        done,
   input logic        irq,
   input logic        cfg_err,
   input logic        link_trig
);
   AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid && !desc_load) |=> ($stable(acc_src) && $stable(acc_dst))); // R1

   AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R6

   AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy)); // R6

   AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done); // R7

   AST_LINK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      link_trig |=> !link_trig); // R8

   AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !busy); // R9
endmodule

bind dma2d_addr_seq dma2d_addr_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .desc_load (desc_load),
   .acc_valid (acc_valid),
   .acc_src   (acc_src),
   .acc_dst   (acc_dst),
   .busy      (busy),
   .done      (done),
   .irq       (irq),
   .cfg_err   (cfg_err),
   .link_trig (link_trig)
);

// File: tb/tb_dma2d_addr_seq.sv
`timescale 1ns/1ps
module tb_dma2d_addr_seq;
   localparam int OFF_W  = 16;
   localparam int ITER_W = 15;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              desc_load = 1'b0;
   logic [31:0]       desc_src = '0, desc_dst = '0;
   logic [OFF_W-1:0]  desc_src_step = '0, desc_dst_step = '0;
   logic [31:0]       desc_count_word = '0;
   logic              map_enable = 1'b0;
   logic [ITER_W-1:0] desc_iters = '0;
   logic [31:0]       desc_src_last = '0, desc_dst_last = '0;
   logic              desc_irq_en = 1'b0, desc_link_en = 1'b0;
   logic              start = 1'b0, done_clr = 1'b0;
   logic              acc_valid, busy, done, irq, cfg_err, link_trig;
   logic [31:0]       acc_src, acc_dst;

   always #2.5 clk = ~clk;

   dma2d_addr_seq #(.OFF_W(OFF_W), .ITER_W(ITER_W)) dut (
      .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_src(desc_src),
      .desc_dst(desc_dst), .desc_src_step(desc_src_step), .desc_dst_step(desc_dst_step),
      .desc_count_word(desc_count_word), .map_enable(map_enable), .desc_iters(desc_iters),
      .desc_src_last(desc_src_last), .desc_dst_last(desc_dst_last),
      .desc_irq_en(desc_irq_en), .desc_link_en(desc_link_en), .start(start),
      .done_clr(done_clr), .acc_valid(acc_valid), .acc_src(acc_src), .acc_dst(acc_dst),
      .busy(busy), .done(done), .irq(irq), .cfg_err(cfg_err), .link_trig(link_trig)
   );

   int checks = 0, errors = 0;

   // descriptor currently programmed, and modelled addresses
   logic [31:0] g_src, g_dst, g_word, g_sl, g_dl;
   logic [15:0] g_ss, g_ds;
   logic        g_map, g_ie, g_le;
   int          g_it;
   logic [31:0] m_src = '0, m_dst = '0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   function automatic void decode(input logic [31:0] w, input logic map,
                                  output logic [31:0] nb, output logic [31:0] lo,
                                  output logic se, output logic de);
      nb = w; lo = '0; se = 1'b0; de = 1'b0;
      if (map && (w[31] || w[30])) begin
         nb = {22'd0, w[9:0]};
         lo = {{12{w[29]}}, w[29:10]};
         se = w[31]; de = w[30];
      end else if (map) begin
         nb = {2'b00, w[29:0]};
      end
   endfunction

   function automatic logic [31:0] sext(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   task automatic load_desc();
      desc_src = g_src; desc_dst = g_dst; desc_src_step = g_ss; desc_dst_step = g_ds;
      desc_count_word = g_word; map_enable = g_map; desc_iters = ITER_W'(g_it);
      desc_src_last = g_sl; desc_dst_last = g_dl; desc_irq_en = g_ie; desc_link_en = g_le;
      desc_load = 1'b1;
      @(negedge clk);
      desc_load = 1'b0;
      m_src = g_src; m_dst = g_dst;
   endtask

   task automatic run(input bit poke);
      logic [31:0] nb, lo;
      logic se, de;
      int n_acc;
      decode(g_word, g_map, nb, lo, se, de);
      n_acc = int'(nb / 4);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R6", "done cleared by start", {31'd0, done}, 32'd0);
      for (int it = 0; it < g_it; it++) begin
         for (int a = 0; a < n_acc; a++) begin
            chk("R2", "acc_valid", {31'd0, acc_valid}, 32'd1);
            chk("R1", "acc_src", acc_src, m_src);
            chk("R1", "acc_dst", acc_dst, m_dst);
            if (poke && it == 0 && a == 0) begin
               // R10: start and load mid-run must leave the stream alone
               start = 1'b1; desc_load = 1'b1;
               desc_src = ~m_src; desc_dst = ~m_dst; desc_iters = '0;
            end
            m_src = m_src + sext(g_ss);
            m_dst = m_dst + sext(g_ds);
            if (a == n_acc - 1) begin
               if (it == g_it - 1) begin
                  m_src = m_src + g_sl;   // R5
                  m_dst = m_dst + g_dl;
               end else begin
                  if (se) m_src = m_src + lo;   // R4
                  if (de) m_dst = m_dst + lo;
               end
            end
            @(negedge clk);
            start = 1'b0; desc_load = 1'b0;
         end
      end
      chk("R6", "busy after final access", {31'd0, busy}, 32'd0);
      chk("R6", "done after final access", {31'd0, done}, 32'd1);
      chk("R7", "irq", {31'd0, irq}, {31'd0, g_ie});
      chk("R5", "final src", acc_src, m_src);
      chk("R5", "final dst", acc_dst, m_dst);
      chk("R8", "link at done", {31'd0, link_trig}, 32'd0);
      @(negedge clk);
      chk("R8", "link +1", {31'd0, link_trig}, 32'd0);
      @(negedge clk);
      chk("R8", "link +2", {31'd0, link_trig}, {31'd0, g_le});
      @(negedge clk);
      chk("R8", "link +3", {31'd0, link_trig}, 32'd0);
      chk("R6", "done held", {31'd0, done}, 32'd1);
   endtask

   task automatic bad_start(input string what);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9", {what, " cfg_err"}, {31'd0, cfg_err}, 32'd1);
      chk("R9", {what, " busy"}, {31'd0, busy}, 32'd0);
      @(negedge clk);
      chk("R9", {what, " no access"}, {31'd0, acc_valid}, 32'd0);
      chk("R9", {what, " src unmoved"}, acc_src, m_src);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected finished");
      report();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6", "reset busy", {31'd0, busy}, 32'd0);
      chk("R6", "reset done", {31'd0, done}, 32'd0);
      chk("R7", "reset irq", {31'd0, irq}, 32'd0);
      chk("R9", "reset cfg_err", {31'd0, cfg_err}, 32'd0);
      chk("R8", "reset link", {31'd0, link_trig}, 32'd0);
      chk("R1", "reset src", acc_src, 32'd0);

      // R3 R4: four 16-byte lines, shared line offset 0x30 on both sides
      g_src = 32'h0000_1000; g_dst = 32'h0000_8000; g_ss = 16'd4; g_ds = 16'd4;
      g_word = 32'hC000_0000 | (32'h30 << 10) | 32'd16; g_map = 1'b1; g_it = 4;
      g_sl = 32'hFFFF_FF00; g_dl = 32'h0000_0040; g_ie = 1'b1; g_le = 1'b1;
      load_desc();
      run(1'b0);
      chk("R5", "worked case src", acc_src, 32'h0000_0FD0);
      // R11: rerun with no load, with a mid-run start/load poke (R10)
      run(1'b1);
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      chk("R6", "done_clr done", {31'd0, done}, 32'd0);
      chk("R7", "done_clr irq", {31'd0, irq}, 32'd0);

      // R4: source-only negative line offset, negative destination step
      g_src = 32'h0000_4000; g_dst = 32'h0001_0000; g_ss = 16'd4; g_ds = 16'hFFFC;
      g_word = 32'h8000_0000 | ((32'hFFFC0 & 32'hFFFFF) << 10) | 32'd8; g_it = 3;
      g_sl = 32'd0; g_dl = 32'd0; g_ie = 1'b0; g_le = 1'b0;
      load_desc();
      run(1'b0);

      // R3: plain count word with the mapping disabled
      g_map = 1'b0; g_word = 32'd12; g_it = 2; g_sl = 32'h10; g_dl = 32'h20;
      load_desc();
      run(1'b0);

      // R5: wraparound past the top of the address space, one access per line
      g_src = 32'hFFFF_FFF8; g_dst = 32'hFFFF_FFFC; g_ss = 16'd4; g_ds = 16'd8;
      g_map = 1'b1; g_word = 32'hC000_0000 | (32'h7 << 10) | 32'd4; g_it = 3;
      g_sl = 32'h8; g_dl = 32'hFFFF_FFF0; g_ie = 1'b1; g_le = 1'b1;
      load_desc();
      run(1'b0);

      // R9: rejected starts
      g_word = 32'd0; g_map = 1'b0; g_it = 2;
      load_desc();
      bad_start("zero count");
      g_word = 32'd6;
      load_desc();
      chk("R9", "load clears cfg_err", {31'd0, cfg_err}, 32'd0);
      bad_start("unaligned count");
      g_word = 32'd8; g_it = 0;
      load_desc();
      bad_start("zero iterations");
      g_word = 32'h8000_0000 | (32'h5 << 10); g_map = 1'b1; g_it = 1;
      load_desc();
      bad_start("mapped zero count");
      g_word = 32'd4; g_map = 1'b0;
      load_desc();
      run(1'b0);
      chk("R9", "valid start clears cfg_err", {31'd0, cfg_err}, 32'd0);

      // random descriptors
      for (int n = 0; n < 60; n++) begin
         logic [1:0] sel;
         logic [31:0] nbv;
         bit skip;
         skip = (($urandom % 3) == 0);
         if (!skip) begin
            g_src = $urandom; g_dst = $urandom;
            g_ss = 16'($urandom); g_ds = 16'($urandom);
            g_sl = $urandom; g_dl = $urandom;
            g_ie = 1'($urandom); g_le = 1'($urandom);
            g_it = 1 + int'($urandom % 4);
            nbv = 32'(4 * (1 + ($urandom % 4)));
            g_map = 1'($urandom);
            sel = 2'($urandom);
            if (g_map && sel != 2'b00)
               g_word = {sel, 20'($urandom), nbv[9:0]};
            else
               g_word = nbv;
            load_desc();
         end
         run(($urandom % 4) == 0);
      end
      report();
   end
endmodule